// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave-side protocol engine of a small serial nonvolatile memory. It watches chip select, serial clock, serial data in and a pause input, and it drives serial data out together with an output enable. All four serial inputs are brought into the system clock domain through synchronizers, and the edges are detected there. This keeps every register on one clock. The serial clock must therefore run well below the system clock; a few system cycles per serial half period are enough.

Each selection starts with an 8-bit command. Array reads take a 16-bit address and then stream bytes from a synchronous 8K x 8 memory for as long as clocks arrive. The address steps after each byte and wraps at the top of the array. Status reads repeat the status byte supplied by the protection logic. Writes are not performed here. Write-enable changes, status writes and array writes are passed on to neighbouring write and protection blocks as one-cycle request pulses. Each request is issued only when chip select rises at a bit count that makes the command valid.

Top module: `spi_front_top`

## Requirements
- R1: Both idle clock polarities are supported (serial modes 0 and 3). Data in is sampled on the rising serial clock edge and data out changes after the falling edge. Every byte travels most significant bit first.
- R2: After reset, no command is taken until chip select has made a high-to-low transition. Chip select that is already low when reset is released does not start a command.
- R3: The command codes are 0x06 enable writes, 0x04 disable writes, 0x05 status read, 0x01 status write, 0x03 array read and 0x02 array write. Any other code issues no request and leaves the output disabled until chip select rises.
- R4: An array read (0x03) takes a 16-bit address, of which only the low 13 bits are used. Bytes are then shifted out from successive addresses, and the address wraps from 0x1FFF to 0x0000.
- R5: A status read (0x05) shifts out the `statusIn` byte and repeats it for as long as clocking continues. It is accepted at any time.
- R6: While chip select is high, `misoEn` is 0, and a partial command is discarded when chip select rises.
- R7: The write-enable commands (0x06 or 0x04) pulse `weSetReq` or `weClrReq` only when chip select rises right after the eighth bit. Any further clock edge cancels the command.
- R8: A status write (0x01) pulses `statWrReq`, with the data byte on `statWrData`, only when chip select rises right after the sixteenth bit.
- R9: During an array write (0x02), each complete data byte gives an `arrWrByte` pulse carrying `memAddr` and `arrWrData`. The address then steps within its 32-byte page: the low 5 bits wrap and the upper bits stay.
- R10: `arrWrCommit` pulses when chip select rises on a byte boundary after at least one data byte. This also holds when the rise lands in the same cycle as the last byte's strobe. A rise in the middle of a byte gives no commit.
- R11: While `holdN` is low, clock and data-in edges are ignored and `misoEn` is 0. The transfer resumes at the same bit when `holdN` returns high.
- R12: The command requests (`weSetReq`, `weClrReq`, `statWrReq`, `arrWrCommit`) are one system cycle wide, and no two of them are active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| holdN | input | 1 | Pause, active low |
| miso | output | 1 | Serial data out |
| misoEn | output | 1 | Output enable for `miso` (high-impedance when 0) |
| memAddr | output | 13 | Byte address for array reads and write strobes |
| memRdEn | output | 1 | Read strobe to the synchronous memory |
| memRdData | input | 8 | Memory data, valid one cycle after `memRdEn` |
| statusIn | input | 8 | Status byte from the protection block |
| weSetReq | output | 1 | Request to set the write-enable latch |
| weClrReq | output | 1 | Request to clear the write-enable latch |
| statWrReq | output | 1 | Request to write the status register |
| statWrData | output | 8 | Data for the status write |
| arrWrByte | output | 1 | Strobe for one array data byte |
| arrWrData | output | 8 | Data byte for the array write |
| arrWrCommit | output | 1 | Array write sequence ended validly |

## Verification
The strobe for the final data byte of an array write and the commit caused by chip select rising can fall in the same system cycle. In that cycle the page address also steps while the sequence closes. The bench provokes this by raising chip select one system cycle after the last rising clock edge, so both synchronized events are detected together. It then checks that the byte strobe, its address and data, and the commit are each seen exactly once. A second coincidence is a pause taken mid-byte during a read. The bench judges it by the byte value returned after release and by the address of the byte that follows.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  localparam logic [7:0] OP_WE_SET   = 8'h06;
  localparam logic [7:0] OP_WE_CLR   = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_ARR_RD   = 8'h03;
  localparam logic [7:0] OP_ARR_WR   = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADRH, ST_ADRL, ST_RDAT, ST_RSTAT,
    ST_WSTAT, ST_WDAT, ST_ARM, ST_STARM, ST_SKIP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic rxShift;
    logic rxClr;
    logic addrHiLd;
    logic addrLoLd;
    logic addrInc;
    logic addrIncPage;
    logic fetch;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
    logic txStop;
    logic outGate;
  } dpCtl_t;

endpackage

// File: rtl/spi_front_sync.sv
module spi_front_sync #(
  parameter int LINES = 4,
  parameter int STAGES = 2,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] async,
  output logic [LINES-1:0] level
);
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= {STAGES{RST_VAL[g]}};
      else       pipe <= {pipe[STAGES-2:0], async[g]};
    end
    assign level[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_front_dp.sv
module spi_front_dp
  import spi_front_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              siBit,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        statusIn,
  output logic [7:0]        rxNext,
  output logic              lastBitNow,
  output logic              bitCntZero,
  output logic              txBitZero,
  output logic [7:0]        lastByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  output logic              miso,
  output logic              misoEn
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0]        rxReg, nextByte, txReg;
  logic [2:0]        bitCnt, txBit;
  logic [ADDR_W-1:0] addrReg;
  logic              memValid, txActive;

  assign rxNext     = {rxReg[6:0], siBit};
  assign lastBitNow = (bitCnt == 3'd7);
  assign bitCntZero = (bitCnt == 3'd0);
  assign txBitZero  = (txBit == 3'd0);
  assign memAddr    = addrReg;
  assign miso       = txReg[7];
  assign misoEn     = txActive & ctl.outGate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg <= '0; bitCnt <= '0; lastByte <= '0;
    end else if (ctl.rxClr) begin
      bitCnt <= '0;
    end else if (ctl.rxShift) begin
      rxReg  <= rxNext;
      bitCnt <= bitCnt + 3'd1;
      if (lastBitNow) lastByte <= rxNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addrReg <= '0;
    else if (ctl.addrHiLd) addrReg[ADDR_W-1:8] <= rxNext[HI_W-1:0];
    else if (ctl.addrLoLd) addrReg[7:0] <= rxNext;
    else if (ctl.addrInc) addrReg <= addrReg + 1'b1;
    else if (ctl.addrIncPage) addrReg[PAGE_W-1:0] <= addrReg[PAGE_W-1:0] + 1'b1;
  end

  // read prefetch: one fetch in flight, captured one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRdEn <= 1'b0; memValid <= 1'b0; nextByte <= '0;
    end else begin
      memRdEn  <= ctl.fetch;
      memValid <= memRdEn;
      if (memValid) nextByte <= memRdData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0; txBit <= '0; txActive <= 1'b0;
    end else if (ctl.txStop) begin
      txBit <= '0; txActive <= 1'b0;
    end else if (ctl.txLoadMem || ctl.txLoadStat) begin
      txReg    <= ctl.txLoadMem ? nextByte : statusIn;
      txBit    <= 3'd1;
      txActive <= 1'b1;
    end else if (ctl.txShift) begin
      txReg <= {txReg[6:0], 1'b0};
      txBit <= txBit + 3'd1;
    end
  end
endmodule

// File: rtl/spi_front_ctrl.sv
module spi_front_ctrl
  import spi_front_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckLvl,
  input  logic       csLvl,
  input  logic       holdLvl,
  input  logic       lastBitNow,
  input  logic       bitCntZero,
  input  logic       txBitZero,
  input  logic [7:0] rxNext,
  output dpCtl_t     ctl,
  output logic       csRise,
  output logic       weSetReq,
  output logic       weClrReq,
  output logic       statWrReq,
  output logic       arrWrByte,
  output logic       arrWrCommit
);
  phase_t state, stateNx;
  logic sckPrev, csPrev, csFall, active, sckRise, sckFall;
  logic armSet, armSetNx, isRead, isReadNx, gotByte;
  logic setNx, clrNx, statNx, commitNx, wrPulseNx;

  assign csRise  = csLvl & ~csPrev;
  assign csFall  = ~csLvl & csPrev;
  assign active  = ~csLvl & holdLvl;
  assign sckRise = active & sckLvl & ~sckPrev;
  assign sckFall = active & ~sckLvl & sckPrev;

  always_comb begin
    ctl = '0;
    ctl.outGate = holdLvl & ~csLvl;
    stateNx = state; armSetNx = armSet; isReadNx = isRead;
    setNx = 1'b0; clrNx = 1'b0; statNx = 1'b0; commitNx = 1'b0; wrPulseNx = 1'b0;
    ctl.addrIncPage = arrWrByte;
    if (csRise) begin
      stateNx = ST_IDLE;
      ctl.rxClr = 1'b1;
      ctl.txStop = 1'b1;
      case (state)
        ST_ARM:   begin setNx = armSet; clrNx = ~armSet; end
        ST_STARM: statNx = 1'b1;
        ST_WDAT:  commitNx = bitCntZero & (gotByte | arrWrByte);
        default:  ;
      endcase
    end else if (csFall) begin
      stateNx = ST_OPC;
      ctl.rxClr = 1'b1;
      ctl.txStop = 1'b1;
    end else begin
      if (sckRise) begin
        case (state)
          ST_IDLE, ST_SKIP, ST_RDAT, ST_RSTAT: ;
          ST_ARM, ST_STARM: stateNx = ST_SKIP;
          default: begin
            ctl.rxShift = 1'b1;
            if (lastBitNow) begin
              case (state)
                ST_OPC: begin
                  case (rxNext)
                    OP_WE_SET:  begin stateNx = ST_ARM; armSetNx = 1'b1; end
                    OP_WE_CLR:  begin stateNx = ST_ARM; armSetNx = 1'b0; end
                    OP_STAT_RD: stateNx = ST_RSTAT;
                    OP_STAT_WR: stateNx = ST_WSTAT;
                    OP_ARR_RD:  begin stateNx = ST_ADRH; isReadNx = 1'b1; end
                    OP_ARR_WR:  begin stateNx = ST_ADRH; isReadNx = 1'b0; end
                    default:    stateNx = ST_SKIP;
                  endcase
                end
                ST_ADRH: begin ctl.addrHiLd = 1'b1; stateNx = ST_ADRL; end
                ST_ADRL: begin
                  ctl.addrLoLd = 1'b1;
                  ctl.fetch = isRead;
                  stateNx = isRead ? ST_RDAT : ST_WDAT;
                end
                ST_WSTAT: stateNx = ST_STARM;
                ST_WDAT:  wrPulseNx = 1'b1;
                default:  ;
              endcase
            end
          end
        endcase
      end
      if (sckFall) begin
        if (state == ST_RDAT) begin
          ctl.txLoadMem = txBitZero;
          ctl.addrInc   = txBitZero;
          ctl.fetch     = txBitZero;
          ctl.txShift   = ~txBitZero;
        end else if (state == ST_RSTAT) begin
          ctl.txLoadStat = txBitZero;
          ctl.txShift    = ~txBitZero;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; sckPrev <= 1'b0; csPrev <= 1'b0;
      armSet <= 1'b0; isRead <= 1'b0; gotByte <= 1'b0;
      weSetReq <= 1'b0; weClrReq <= 1'b0; statWrReq <= 1'b0;
      arrWrByte <= 1'b0; arrWrCommit <= 1'b0;
    end else begin
      state <= stateNx; sckPrev <= sckLvl; csPrev <= csLvl;
      armSet <= armSetNx; isRead <= isReadNx;
      if (csFall) gotByte <= 1'b0;
      else if (arrWrByte) gotByte <= 1'b1;
      weSetReq <= setNx; weClrReq <= clrNx; statWrReq <= statNx;
      arrWrByte <= wrPulseNx; arrWrCommit <= commitNx;
    end
  end
endmodule

// File: rtl/spi_front_top.sv
module spi_front_top
  import spi_front_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              holdN,
  output logic              miso,
  output logic              misoEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        statusIn,
  output logic              weSetReq,
  output logic              weClrReq,
  output logic              statWrReq,
  output logic [7:0]        statWrData,
  output logic              arrWrByte,
  output logic [7:0]        arrWrData,
  output logic              arrWrCommit
);
  localparam int LINES = 4;
  // lines: 3 hold, 2 chip select (resets low so reset never looks like a fall), 1 data, 0 clock
  localparam logic [LINES-1:0] SYNC_RST = 4'b1000;

  logic [LINES-1:0] syncLvl;
  logic csLvl, holdLvl, csRise;
  logic lastBitNow, bitCntZero, txBitZero;
  logic [7:0] rxNext, lastByte;
  dpCtl_t ctl;

  assign csLvl   = syncLvl[2];
  assign holdLvl = syncLvl[3];
  assign statWrData = lastByte;
  assign arrWrData  = lastByte;

  spi_front_sync #(.LINES(LINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) uSync (
    .clk(clk), .rstN(rstN), .async({holdN, csN, mosi, sclk}), .level(syncLvl)
  );

  spi_front_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sckLvl(syncLvl[0]), .csLvl(csLvl), .holdLvl(holdLvl),
    .lastBitNow(lastBitNow), .bitCntZero(bitCntZero), .txBitZero(txBitZero),
    .rxNext(rxNext), .ctl(ctl), .csRise(csRise), .weSetReq(weSetReq),
    .weClrReq(weClrReq), .statWrReq(statWrReq), .arrWrByte(arrWrByte),
    .arrWrCommit(arrWrCommit)
  );

  spi_front_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .siBit(syncLvl[1]), .memRdData(memRdData),
    .statusIn(statusIn), .rxNext(rxNext), .lastBitNow(lastBitNow),
    .bitCntZero(bitCntZero), .txBitZero(txBitZero), .lastByte(lastByte),
    .memAddr(memAddr), .memRdEn(memRdEn), .miso(miso), .misoEn(misoEn)
  );
endmodule

// File: rtl/spi_front_chk.sv
module spi_front_chk #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              csRise,
  input logic              holdLvl,
  input logic [ADDR_W-1:0] memAddr,
  input logic              arrWrByte,
  input logic              weSetReq,
  input logic              weClrReq,
  input logic              statWrReq,
  input logic              arrWrCommit
);
  a_r7_enable_on_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    (weSetReq || weClrReq) |-> $past(csRise));

  a_r10_commit_on_cs_rise: assert property (@(posedge clk) disable iff (!rstN)
    arrWrCommit |-> $past(csRise));

  a_r9_page_step: assert property (@(posedge clk) disable iff (!rstN)
    arrWrByte |=> (memAddr[PAGE_W-1:0] == $past(memAddr[PAGE_W-1:0]) + 1'b1)
                  && (memAddr[ADDR_W-1:PAGE_W] == $past(memAddr[ADDR_W-1:PAGE_W])));

  a_r11_hold_freezes_addr: assert property (@(posedge clk) disable iff (!rstN)
    (!holdLvl && $past(!holdLvl)) |=> $stable(memAddr));

  a_r12_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({weSetReq, weClrReq, statWrReq, arrWrCommit}));

  a_r12_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (weSetReq || statWrReq || arrWrCommit) |=> !(weSetReq || statWrReq || arrWrCommit));
endmodule

bind spi_front_top spi_front_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .csRise(csRise), .holdLvl(holdLvl), .memAddr(memAddr),
  .arrWrByte(arrWrByte), .weSetReq(weSetReq), .weClrReq(weClrReq),
  .statWrReq(statWrReq), .arrWrCommit(arrWrCommit)
);

// File: tb/spi_front_top_test.sv
`timescale 1ns/1ps
module spi_front_top_test;
  localparam int H = 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic csN = 1'b0, sclk = 1'b0, mosi = 1'b0, holdN = 1'b1;
  logic miso, misoEn, memRdEn, weSetReq, weClrReq, statWrReq, arrWrByte, arrWrCommit;
  logic [12:0] memAddr;
  logic [7:0] memRdData = 8'h00, statusIn = 8'h00, statWrData, arrWrData;

  int nChk = 0, nFail = 0;
  bit done = 1'b0, mode3 = 1'b0;
  int cntSet, cntClr, cntStat, cntByte, cntCommit;
  logic [7:0] statData;
  logic [12:0] byteAddr [0:7];
  logic [7:0]  byteData [0:7];

  always #2 clk = ~clk;

  spi_front_top uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .holdN(holdN),
    .miso(miso), .misoEn(misoEn), .memAddr(memAddr), .memRdEn(memRdEn),
    .memRdData(memRdData), .statusIn(statusIn), .weSetReq(weSetReq),
    .weClrReq(weClrReq), .statWrReq(statWrReq), .statWrData(statWrData),
    .arrWrByte(arrWrByte), .arrWrData(arrWrData), .arrWrCommit(arrWrCommit)
  );

  function automatic logic [7:0] patt(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
  endfunction

  // synchronous memory model
  always @(posedge clk) if (memRdEn) memRdData <= patt(memAddr);

  // request monitors
  always @(negedge clk) begin
    if (weSetReq) cntSet++;
    if (weClrReq) cntClr++;
    if (statWrReq) begin cntStat++; statData = statWrData; end
    if (arrWrCommit) cntCommit++;
    if (arrWrByte) begin
      if (cntByte < 8) begin byteAddr[cntByte] = memAddr; byteData[cntByte] = arrWrData; end
      cntByte++;
    end
  end

  task automatic clearMon();
    cntSet = 0; cntClr = 0; cntStat = 0; cntByte = 0; cntCommit = 0; statData = 8'h00;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic csLow(input bit m3);
    mode3 = m3; sclk = m3; tick(H);
    csN = 1'b0; tick(H);
  endtask

  task automatic csHigh();
    tick(H); csN = 1'b1; tick(2*H);
  endtask

  task automatic bitX(input logic b, output logic r, output logic en);
    if (mode3) sclk = 1'b0;
    mosi = b; tick(H);
    r = miso; en = misoEn;
    sclk = 1'b1; tick(H);
    if (!mode3) sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] en);
    for (int i = 7; i >= 0; i--) bitX(tx[i], rx[i], en[i]);
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    logic r, e;
    for (int i = n - 1; i >= 0; i--) bitX(v[i], r, e);
  endtask

  task automatic sendByte(input logic [7:0] v);
    sendBits({24'h0, v}, 8);
  endtask

  task automatic tReset();
    chk("R6 reset misoEn", misoEn, 0);
    chk("R12 reset requests", {weSetReq, weClrReq, statWrReq, arrWrCommit, arrWrByte}, 0);
    chk("R4 reset memRdEn", memRdEn, 0);
  endtask

  task automatic tNoFallAfterReset();   // R2
    clearMon(); mode3 = 1'b0;
    sendByte(8'h06); tick(H); csN = 1'b1; tick(2*H);
    chk("R2 no command without cs fall", cntSet, 0);
  endtask

  task automatic tWeSet(input bit m3);  // R7 R1
    clearMon(); csLow(m3); sendByte(8'h06); csHigh();
    chk(m3 ? "R1 mode3 enable set" : "R7 enable set", cntSet, 1);
    chk("R7 no clear", cntClr, 0);
  endtask

  task automatic tWeExtra();
    clearMon(); csLow(0); sendBits(32'h0C, 9); csHigh();
    chk("R7 ninth bit cancels", cntSet, 0);
    clearMon(); csLow(0); sendByte(8'h04); csHigh();
    chk("R7 enable clear", cntClr, 1);
    chk("R7 clear only", cntSet, 0);
  endtask

  task automatic tRead(input bit m3, input logic [15:0] addr, input int n);
    logic [7:0] rx, en;
    csLow(m3); sendByte(8'h03); sendByte(addr[15:8]); sendByte(addr[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rx, en);
      chk(m3 ? "R1 mode3 read byte" : "R4 read byte", rx, patt(addr[12:0] + 13'(i)));
      chk("R1 output driven", en, 8'hFF);
    end
    csHigh();
    chk("R6 deselected hiz", misoEn, 0);
  endtask

  task automatic tStatus(input bit m3, input logic [7:0] v);
    logic [7:0] rx, en;
    statusIn = v; csLow(m3); sendByte(8'h05);
    for (int i = 0; i < 2; i++) begin
      xfer(8'h00, rx, en);
      chk("R5 status byte", rx, v);
    end
    csHigh();
  endtask

  task automatic tStatWrite();
    clearMon(); csLow(0); sendByte(8'h01); sendByte(8'h8C); csHigh();
    chk("R8 status write req", cntStat, 1);
    chk("R8 status data", statData, 8'h8C);
    clearMon(); csLow(0); sendByte(8'h01); sendBits(32'h46, 7); csHigh();
    chk("R8 short status write", cntStat, 0);
    clearMon(); csLow(1); sendByte(8'h01); sendByte(8'h8C); sendBits(32'h1, 1); csHigh();
    chk("R8 long status write", cntStat, 0);
  endtask

  task automatic tArrWrite();
    clearMon(); csLow(0); sendByte(8'h02); sendByte(8'h00); sendByte(8'h3E);
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); csHigh();
    chk("R9 byte strobes", cntByte, 3);
    chk("R9 addr 0", byteAddr[0], 13'h003E);
    chk("R9 addr 1", byteAddr[1], 13'h003F);
    chk("R9 page wrap", byteAddr[2], 13'h0020);
    chk("R9 data 2", byteData[2], 8'h33);
    chk("R10 commit", cntCommit, 1);
    clearMon(); csLow(0); sendByte(8'h02); sendByte(8'h00); sendByte(8'h40);
    sendByte(8'h44); sendBits(32'h5, 3); csHigh();
    chk("R10 mid byte strobes", cntByte, 1);
    chk("R10 mid byte no commit", cntCommit, 0);
  endtask

  task automatic tCoincide();   // last byte strobe and cs rise together
    clearMon(); csLow(0); sendByte(8'h02); sendByte(8'h00); sendByte(8'h05);
    sendBits(32'h3B, 7);
    mosi = 1'b1; tick(H); sclk = 1'b1; tick(1); csN = 1'b1; tick(H);
    sclk = 1'b0; tick(2*H);
    chk("R10 coincide strobe", cntByte, 1);
    chk("R10 coincide addr", byteAddr[0], 13'h0005);
    chk("R10 coincide data", byteData[0], 8'h77);
    chk("R10 coincide commit", cntCommit, 1);
  endtask

  task automatic tHold();
    logic [7:0] rx, en;
    logic r, e;
    csLow(0); sendByte(8'h03); sendByte(8'h02); sendByte(8'h00);
    for (int i = 7; i >= 4; i--) begin bitX(1'b0, r, e); rx[i] = r; end
    tick(H); holdN = 1'b0; tick(H);
    chk("R11 paused hiz", misoEn, 0);
    for (int k = 0; k < 2; k++) begin
      mosi = ~mosi; sclk = 1'b1; tick(H); sclk = 1'b0; tick(H);
      chk("R11 paused hiz during clocks", misoEn, 0);
    end
    holdN = 1'b1; tick(H);
    for (int i = 3; i >= 0; i--) begin bitX(1'b0, r, e); rx[i] = r; end
    chk("R11 byte resumes", rx, patt(13'h0200));
    xfer(8'h00, rx, en);
    chk("R11 next address", rx, patt(13'h0201));
    csHigh();
  endtask

  task automatic tUnknownAndPartial();
    logic [7:0] rx, en;
    clearMon(); csLow(0); sendByte(8'hFF);
    xfer(8'h00, rx, en); chk("R3 unknown keeps hiz", en, 8'h00);
    xfer(8'h06, rx, en); chk("R3 unknown keeps hiz 2", en, 8'h00);
    csHigh();
    chk("R3 unknown no request", cntSet + cntClr + cntStat + cntCommit + cntByte, 0);
    clearMon(); csLow(0); sendBits(32'h0, 4); csHigh();
    csLow(0); sendBits(32'h6, 4); csHigh();
    chk("R6 partial discarded", cntSet, 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    clearMon();
    tick(10); rstN = 1'b1; tick(5);
    tReset();
    tNoFallAfterReset();
    tWeSet(0);
    tWeSet(1);
    tWeExtra();
    tRead(0, 16'hFFFE, 3);
    tRead(1, 16'h0123, 2);
    tStatus(0, 8'hA5);
    tStatus(1, 8'h03);
    tStatWrite();
    tArrWrite();
    tCoincide();
    tHold();
    tUnknownAndPartial();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule